// File: doc/BRIEF.md
# Lookup-Table Gaussian Pulse Shaper

This block turns a serial stream of data bits into a sampled, Gaussian-smoothed baseband waveform. A frequency-modulating transmitter uses that waveform, and an external DAC converts it. Each bit counts as an antipodal symbol: a 0 becomes -1 and a 1 becomes +1. The block does no multiply-accumulate arithmetic. It keeps the newest few bits in a short history register and counts the sample slots within the current bit period. The history and the slot number together address a constant table. The selected word is registered and presented as an unsigned DAC code, together with a one-cycle valid strobe.

The table is built at elaboration from the truncated pulse response, so the history length, the samples per bit, the code width and the clock-to-sample ratio can all be changed by parameter. A bit strobe loads a new bit and restarts the sample sequence at slot 0. Between strobes the block produces a sample every `DIV` clocks. A bit period normally lasts `M*DIV` clocks.

Top module: `gauss_rom_shaper`

## Requirements
- R1: After synchronous reset, `sample` is the mid code 2^(W-1) and `sample_vld` is 0. The history holds 1 at every even position and 0 at every odd position, where position 0 is the newest bit.
- R2: In a clock cycle with `bit_stb` high, `bit_in` enters history position 0, every other bit moves one position toward the oldest, and the oldest bit is dropped. A stored 1 counts as +1 and a stored 0 counts as -1.
- R3: A strobe sampled at clock edge n restarts the sample phase at 0. `sample_vld` is then high after edge n+1, and `sample` shows the phase-0 entry for the new history.
- R4: When no strobe arrives, a new sample tick occurs every `DIV` clocks after the previous tick. The phase advances by one and wraps from M-1 to 0, and the history does not change.
- R5: `bit_in` has no effect in a cycle without `bit_stb`.
- R6: The table address is {history, phase}: the oldest bit is the MSB, position 0 sits just above the phase field, and the phase takes the PW = clog2(M) low bits. `sample` is the table word at that address, registered one cycle after the tick.
- R7: For history position q, the table uses the offset o = (2j+1-M) - (K-1-2q)*M for phase j, and the weight w = (K²M² - o²)² when |o| < KM, otherwise 0. The code is 2^(W-1) + trunc((2^(W-1)-1) * Σ s_q w_q / Σ w_q), where s_q = ±1. An all-ones history therefore gives 2^W-1 and an all-zeros history gives 1.
- R8: `sample_vld` is high for exactly one cycle per tick, and `sample` holds its value between ticks.
- R9: A strobe may arrive at any time, including in consecutive cycles or part-way through a period. Each strobe restarts the phase and the tick spacing.
- R10: The samples-per-bit, code width, history length and divider are parameters. Ten samples per bit with a 6-bit code is a supported setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Loads `bit_in` and restarts the bit period |
| bit_in | input | 1 | Data bit, 1 = +1, 0 = -1 |
| sample | output | W | Unsigned DAC code |
| sample_vld | output | 1 | One-cycle strobe per new sample |

## Verification
On every cycle, the embedded assertions check these properties:
- The phase stays within range.
- A strobe clears the phase and yields a valid sample two edges later.
- The history either shifts correctly or holds.
- The output holds between ticks.
- An all-ones history gives the full positive code and an all-zeros history gives the full negative code.

The actual table values, the wrap of the phase after M-1, the spacing of ticks, and the fact that `bit_in` is ignored without a strobe are shown only by the bench. It runs a behavioural model against each clock under pseudo-random, irregular and back-to-back strobe patterns. It does this at both the default setting and the ten-sample setting.

// File: rtl/gps_pkg.sv
package gps_pkg;

  // Unsigned DAC code for one history pattern at one phase.
  // hist bit q: q = 0 newest. Offsets are in units of 1/(2m) bit.
  function automatic int gps_code(input int k, input int m, input int w,
                                  input int hist, input int ph);
    int     half;
    int     span;
    int     off;
    longint d;
    longint wt;
    longint num;
    longint den;
    half = 1 << (w - 1);
    if (ph >= m) return half;
    span = k * m;
    num  = 0;
    den  = 0;
    for (int q = 0; q < k; q++) begin
      off = (2 * ph + 1 - m) - (k - 1 - 2 * q) * m;
      if (off < 0) off = -off;
      if (off < span) begin
        d  = longint'(span * span - off * off);
        wt = d * d;
      end else begin
        wt = 0;
      end
      den = den + wt;
      num = num + ((((hist >> q) & 1) != 0) ? wt : -wt);
    end
    return half + int'((longint'(half - 1) * num) / den);
  endfunction

endpackage

// File: rtl/gps_hist.sv
module gps_hist #(
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         din,
  output logic [K-1:0] hist
);

  logic [K-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) hist_q[i] <= ((i % 2) == 0);
    end else if (load) begin
      hist_q <= {hist_q[K-2:0], din};
    end
  end

  assign hist = hist_q;

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    load |=> hist_q[0] == $past(din));                          // R2
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    load |=> hist_q[K-1:1] == $past(hist_q[K-2:0]));            // R2
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hist_q));                                 // R5

endmodule

// File: rtl/gps_phase.sv
module gps_phase #(
  parameter int M   = 6,
  parameter int DIV = 4,
  localparam int PW  = (M > 1) ? $clog2(M) : 1,
  localparam int PRW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [PW-1:0] phase,
  output logic          tick
);

  logic [PRW-1:0] pre_q;
  logic [PW-1:0]  phase_q;
  logic           tick_q;
  logic           pre_end;

  assign pre_end = (pre_q == PRW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else if (restart) begin
      pre_q   <= '0;
      phase_q <= '0;
      tick_q  <= 1'b1;
    end else if (pre_end) begin
      pre_q   <= '0;
      phase_q <= (phase_q == PW'(M - 1)) ? '0 : phase_q + 1'b1;
      tick_q  <= 1'b1;
    end else begin
      pre_q   <= pre_q + 1'b1;
      tick_q  <= 1'b0;
    end
  end

  assign phase = phase_q;
  assign tick  = tick_q;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PW'(M - 1));                                     // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0) && tick_q);                     // R3

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_q && !restart) |=> !tick_q);                      // R8
    end
  endgenerate

endmodule

// File: rtl/gps_rom.sv
module gps_rom #(
  parameter int K = 3,
  parameter int M = 6,
  parameter int W = 8,
  localparam int PW    = (M > 1) ? $clog2(M) : 1,
  localparam int AW    = K + PW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  dout,
  output logic          dout_vld
);

  logic [W-1:0] rom [DEPTH];

  generate
    for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
      localparam int CODE = gps_pkg::gps_code(K, M, W, a >> PW, a % (1 << PW));
      assign rom[a] = W'(CODE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= W'(1 << (W - 1));
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_en;
      if (rd_en) dout <= rom[addr];
    end
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(dout));                                  // R8

endmodule

// File: rtl/gauss_rom_shaper.sv
module gauss_rom_shaper #(
  parameter int K   = 3,
  parameter int M   = 6,
  parameter int W   = 8,
  parameter int DIV = 4,
  localparam int PW = (M > 1) ? $clog2(M) : 1,
  localparam int AW = K + PW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_stb,
  input  logic         bit_in,
  output logic [W-1:0] sample,
  output logic         sample_vld
);

  logic [K-1:0]  hist;
  logic [PW-1:0] phase;
  logic          tick;
  logic [AW-1:0] addr;

  gps_hist #(.K(K)) hist_i (
    .clk(clk), .rst(rst), .load(bit_stb), .din(bit_in), .hist(hist)
  );

  gps_phase #(.M(M), .DIV(DIV)) phase_i (
    .clk(clk), .rst(rst), .restart(bit_stb), .phase(phase), .tick(tick)
  );

  assign addr = {hist, phase};

  gps_rom #(.K(K), .M(M), .W(W)) rom_i (
    .clk(clk), .rst(rst), .rd_en(tick), .addr(addr),
    .dout(sample), .dout_vld(sample_vld)
  );

  AST_STB_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> ##1 sample_vld);                                // R3
  AST_FULL_POS: assert property (@(posedge clk) disable iff (rst)
    (tick && (hist == '1)) |=> sample == W'((1 << W) - 1));     // R7
  AST_FULL_NEG: assert property (@(posedge clk) disable iff (rst)
    (tick && (hist == '0)) |=> sample == W'(1));                // R7

endmodule

// File: tb/gauss_rom_shaper_tb_top.sv
`timescale 1ns/1ps

module gps_lane #(
  parameter int K   = 3,
  parameter int M   = 6,
  parameter int W   = 8,
  parameter int DIV = 4,
  parameter int ID  = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   n_chk,
  output int   n_fail
);

  localparam int P    = M * DIV;
  localparam int HALF = 1 << (W - 1);

  logic         bit_stb;
  logic         bit_in;
  logic [W-1:0] sample;
  logic         sample_vld;

  gauss_rom_shaper #(.K(K), .M(M), .W(W), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .sample(sample), .sample_vld(sample_vld)
  );

  // Behavioural reference: queue of bits, newest at the front.
  bit    hq[$];
  int    m_ph, m_pre, m_dout;
  bit    m_pend, m_vld;
  bit    running;
  string cur_tag;
  string lane_tag;
  int    lfsr;

  // Weighted sum over taps as stated in R7.
  function automatic int ref_code(int hbits, int j);
    longint acc, tot, d, wt;
    int     centre, off;
    acc = 0;
    tot = 0;
    for (int q = 0; q < K; q++) begin
      centre = (K - 1 - 2 * q) * M;
      off = 2 * j + 1 - M - centre;
      if (off < 0) off = -off;
      wt = 0;
      if (off < K * M) begin
        d  = longint'(K * K * M * M) - longint'(off * off);
        wt = d * d;
      end
      tot += wt;
      if (hbits[q]) acc += wt; else acc -= wt;
    end
    return HALF + int'((longint'(HALF - 1) * acc) / tot);
  endfunction

  function automatic int hist_val();
    int v = 0;
    for (int q = 0; q < K; q++) if (hq[q]) v |= (1 << q);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hq.delete();
      for (int q = 0; q < K; q++) hq.push_back((q % 2) == 0);
      m_ph = 0; m_pre = 0; m_pend = 0; m_vld = 0; m_dout = HALF;
    end else begin
      m_vld = m_pend;
      if (m_pend) m_dout = ref_code(hist_val(), m_ph);
      if (bit_stb) begin
        hq.push_front(bit_in);
        void'(hq.pop_back());
        m_ph = 0; m_pre = 0; m_pend = 1;
      end else if (m_pre == DIV - 1) begin
        m_ph = (m_ph + 1) % M; m_pre = 0; m_pend = 1;
      end else begin
        m_pre++; m_pend = 0;
      end
    end
  end

  // R8: every-cycle comparison of code and strobe.
  always @(negedge clk) begin
    if (running && !rst) begin
      n_chk++;
      if (int'(sample) != m_dout || sample_vld != m_vld) begin
        n_fail++;
        $display("FAIL %s%s lane%0d: sample %0d vld %0d, expected %0d vld %0d",
                 cur_tag, lane_tag, ID, sample, sample_vld, m_dout, m_vld);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s%s lane%0d: actual %0d expected %0d", tag, lane_tag, ID, act, exp);
    end
  endtask

  task automatic strobe(bit b);
    bit_stb = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    done = 0; n_chk = 0; n_fail = 0; running = 0;
    bit_stb = 0; bit_in = 0; lfsr = 32'h1d2c_3b4a + ID;
    cur_tag = "R1";
    lane_tag = (M == 10) ? " R10" : "";
    @(negedge clk);
    while (rst) @(negedge clk);
    check(int'(sample) == HALF, "R1", int'(sample), HALF);
    check(sample_vld == 1'b0, "R1", int'(sample_vld), 0);
    running = 1;
    idle(P);

    // R7: full-scale extremes.
    cur_tag = "R7";
    for (int i = 0; i < K; i++) begin
      strobe(1'b1);
      if (i < K - 1) idle(P - 1);
    end
    @(negedge clk);
    check(int'(sample) == (1 << W) - 1 && sample_vld, "R7", int'(sample), (1 << W) - 1);
    idle(P - 2);
    for (int i = 0; i < K; i++) begin
      strobe(1'b0);
      if (i < K - 1) idle(P - 1);
    end
    @(negedge clk);
    check(int'(sample) == 1 && sample_vld, "R7", int'(sample), 1);
    idle(P - 2);

    // R3: phase-0 sample two edges after a strobe.
    cur_tag = "R3";
    strobe(1'b1);
    check(sample_vld == 1'b0, "R3", int'(sample_vld), 0);
    @(negedge clk);
    check(sample_vld == 1'b1, "R3", int'(sample_vld), 1);
    idle(P - 2);

    // R5: toggling data without a strobe.
    cur_tag = "R5";
    for (int i = 0; i < 2 * P; i++) begin
      bit_in = ~bit_in;
      @(negedge clk);
    end

    // R4: long idle, phase wraps several times.
    cur_tag = "R4";
    idle(3 * P);

    // R2 and R6: pseudo-random bits at the nominal rate.
    cur_tag = "R6";
    for (int i = 0; i < 40; i++) begin
      next_rand();
      strobe(lfsr[0]);
      idle(P - 1);
    end

    // R9: irregular strobe spacing.
    cur_tag = "R9";
    for (int i = 0; i < 40; i++) begin
      next_rand();
      strobe(lfsr[3]);
      idle(lfsr[8:4] % (P + 4));
    end

    // R2: back-to-back strobes.
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) begin
      next_rand();
      strobe(lfsr[1]);
    end
    idle(2 * P);

    running = 0;
    done = 1;
  end

endmodule

module gauss_rom_shaper_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_a, done_b;
  int   chk_a, chk_b, fail_a, fail_b;
  int   wd_fail = 0;

  always #10 clk = ~clk;

  gps_lane #(.K(3), .M(6), .W(8), .DIV(4), .ID(0)) lane_a (
    .clk(clk), .rst(rst), .done(done_a), .n_chk(chk_a), .n_fail(fail_a)
  );

  // R10: ten samples per bit with a 6-bit code.
  gps_lane #(.K(3), .M(10), .W(6), .DIV(3), .ID(1)) lane_b (
    .clk(clk), .rst(rst), .done(done_b), .n_chk(chk_b), .n_fail(fail_b)
  );

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  initial begin
    fork
      wait (done_a && done_b);
      repeat (150000) @(posedge clk);
    join_any
    if (!(done_a && done_b)) begin
      wd_fail = 1;
      $display("FAIL R8 watchdog: sample stream did not finish, actual 0 expected 1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             chk_a + chk_b + wd_fail, fail_a + fail_b + wd_fail);
    $finish;
  end

endmodule